// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block is the shift-register personality of a small controller's serial port. It moves one 8-bit frame at a time over a single shared data line and drives the shift clock for the far end. A frame goes out when the host writes the transmit buffer. A frame comes in when the host writes the control register with the receive-enable bit set. Only one transfer runs at a time, so the port is half-duplex.

Each bit occupies a fixed number of input clocks: 12 in slow mode and 4 in fast mode. The shift clock is low for the first half of every bit and high for the second half. Bits travel least-significant first. Outgoing data changes while the shift clock is low. Incoming data is captured on the first input clock of the high half.

When a frame finishes, a sticky flag is set: one for transmit, one for receive. Only the host clears a flag, through a dedicated clear strobe. The two mode bits must both be zero for this engine to act. Other values belong to framing modes that live elsewhere, and with them the engine stays idle.

Top module: `ssp_shift_port`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0, both flags are 0, `sclk` is 1 and `sd_oe` is 0.
- R2: A `tx_we` pulse while idle with mode bits `ctrl_rdata[3:2]` = 0 starts a transmit. For 8 bit periods `sd_oe` is 1, and during bit k `sd_out` carries `tx_data[k]` (bit 0 first).
- R3: The bit period is 12 clocks when the fast bit (`ctrl_rdata[1]`) is 0 and 4 clocks when it is 1. Within each period, `sclk` is 0 for the first half and 1 for the second half.
- R4: `tx_flag` is set at the clock edge that ends the 8th bit period. From that edge the engine is idle: `sclk` is 1 and `sd_oe` is 0.
- R5: A control write with `ctrl_wdata[0]` (receive enable) = 1 and `ctrl_wdata[3:2]` = 0, issued while idle, starts a receive. The period is set by `ctrl_wdata[1]` and `sd_oe` stays 0. `sd_in` is sampled on the first clock of each bit's high half, and the first sample becomes bit 0.
- R6: At the edge that ends the 8th receive period, the assembled byte appears on `rx_data` and `rx_flag` is set.
- R7: No receive starts while `rx_flag` is 1.
- R8: A flag stays 1 until its clear strobe is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R9: While a transfer runs, `tx_we` is ignored. A control write changes the stored register but not the period of the transfer in progress.
- R10: With nonzero mode bits, neither `tx_we` nor a receive-enable write starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | {mode[1:0], fast, rx_enable} |
| ctrl_rdata | output | 4 | Stored control register |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| tx_flag | output | 1 | Transmit-complete flag |
| rx_flag | output | 1 | Receive-complete flag |
| tx_flag_clr | input | 1 | Clears tx_flag |
| rx_flag_clr | input | 1 | Clears rx_flag |
| sd_in | input | 1 | Data line as seen from the pad |
| sd_out | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock |

## Verification
A phase counter that runs wrong shows up within one bit period. It shifts the `sclk` edges against the expected half-period pattern, and because receive samples are taken relative to those edges, it also changes the captured byte. A bit counter that is off by one ends the frame early or late. That moves the flag and the return of `sclk` to high by a whole period, so checking every cycle of a frame catches it within that frame. A start-gating fault is visible at once: a transfer that should have been blocked, or a missing one, changes `sclk` within half a period.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_TX   = 2'd1,
    ENG_RX   = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic [1:0] mode;
    logic       fast;
    logic       rx_en;
  } ctrl_reg_t;
endpackage

// File: rtl/ssp_ctrl_regs.sv
module ssp_ctrl_regs
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  output logic       mode_ok,
  output logic       fast_q,
  output logic       rx_req,
  output logic       rx_req_fast
);
  ctrl_reg_t reg_q;
  ctrl_reg_t wr_view;

  assign wr_view = ctrl_reg_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q <= wr_view;
    end
  end

  assign rd_data     = reg_q;
  assign mode_ok     = (reg_q.mode == 2'b00);
  assign fast_q      = reg_q.fast;
  // a receive is requested by the write itself, judged on the written value
  assign rx_req      = wr_en && wr_view.rx_en && (wr_view.mode == 2'b00);
  assign rx_req_fast = wr_view.fast;
endmodule

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int DW       = $clog2(SLOW_DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fast_sel,
  input  logic run,
  output logic sample_now,
  output logic bit_end,
  output logic low_half
);
  localparam logic [DW-1:0] SLOW_V = DW'(SLOW_DIV);
  localparam logic [DW-1:0] FAST_V = DW'(FAST_DIV);

  logic [DW-1:0] div_q;
  logic [DW-1:0] phase_q;
  logic [DW-1:0] half;
  logic [DW-1:0] last;

  assign half = div_q >> 1;
  assign last = div_q - DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= SLOW_V;
      phase_q <= '0;
    end else if (start) begin
      div_q   <= fast_sel ? FAST_V : SLOW_V;
      phase_q <= '0;
    end else if (run) begin
      phase_q <= (phase_q == last) ? '0 : phase_q + DW'(1);
    end
  end

  assign low_half   = phase_q < half;
  assign sample_now = run && (phase_q == half);
  assign bit_end    = run && (phase_q == last);
endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BW     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_go,
  input  logic              rx_go,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sd_in,
  input  logic              sample_now,
  input  logic              bit_end,
  input  logic              tx_clr,
  input  logic              rx_clr,
  output eng_state_e        state,
  output logic              line_bit,
  output logic [DATA_W-1:0] rx_buf,
  output logic              tx_flag,
  output logic              rx_flag
);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  eng_state_e        state_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              frame_end;
  logic              tx_set;
  logic              rx_set;

  assign frame_end = bit_end && (bit_q == LAST_BIT);
  assign tx_set    = frame_end && (state_q == ENG_TX);
  assign rx_set    = frame_end && (state_q == ENG_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_buf  <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          bit_q <= '0;
          if (tx_go) begin
            state_q <= ENG_TX;
            sh_q    <= tx_byte;
          end else if (rx_go) begin
            state_q <= ENG_RX;
          end
        end
        ENG_TX: begin
          if (bit_end) begin
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + BW'(1);
            if (frame_end) state_q <= ENG_IDLE;
          end
        end
        ENG_RX: begin
          if (sample_now) sh_q <= {sd_in, sh_q[DATA_W-1:1]};
          if (bit_end) begin
            bit_q <= bit_q + BW'(1);
            if (frame_end) begin
              state_q <= ENG_IDLE;
              rx_buf  <= sh_q;
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      if (tx_set)      tx_flag <= 1'b1;
      else if (tx_clr) tx_flag <= 1'b0;
      if (rx_set)      rx_flag <= 1'b1;
      else if (rx_clr) rx_flag <= 1'b0;
    end
  end

  assign state    = state_q;
  assign line_bit = sh_q[0];
endmodule

// File: rtl/ssp_shift_port.sv
module ssp_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [3:0]        ctrl_wdata,
  output logic [3:0]        ctrl_rdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_flag,
  output logic              rx_flag,
  input  logic              tx_flag_clr,
  input  logic              rx_flag_clr,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk
);
  localparam int DW = $clog2(SLOW_DIV + 1);

  logic       mode_ok, fast_q, rx_req, rx_req_fast;
  logic       sample_now, bit_end, low_half;
  logic       tx_go, rx_go, eng_busy, line_bit;
  eng_state_e state;

  ssp_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_we), .wr_data(ctrl_wdata),
    .rd_data(ctrl_rdata), .mode_ok(mode_ok), .fast_q(fast_q),
    .rx_req(rx_req), .rx_req_fast(rx_req_fast)
  );

  assign eng_busy = (state != ENG_IDLE);
  assign tx_go    = !eng_busy && tx_we && mode_ok;
  assign rx_go    = !eng_busy && rx_req && !rx_flag && !tx_go;

  ssp_bit_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .DW(DW)) u_timer (
    .clk(clk), .rst(rst), .start(tx_go || rx_go),
    .fast_sel(tx_go ? fast_q : rx_req_fast), .run(eng_busy),
    .sample_now(sample_now), .bit_end(bit_end), .low_half(low_half)
  );

  ssp_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tx_go(tx_go), .rx_go(rx_go), .tx_byte(tx_data),
    .sd_in(sd_in), .sample_now(sample_now), .bit_end(bit_end),
    .tx_clr(tx_flag_clr), .rx_clr(rx_flag_clr), .state(state),
    .line_bit(line_bit), .rx_buf(rx_data), .tx_flag(tx_flag), .rx_flag(rx_flag)
  );

  assign sd_oe  = (state == ENG_TX);
  assign sd_out = sd_oe ? line_bit : 1'b1;
  assign sclk   = !eng_busy || !low_half;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [1:0] mode,
  input logic       ctrl_we,
  input logic       rx_en_wr,
  input logic       tx_we,
  input logic       tx_flag,
  input logic       rx_flag,
  input logic       tx_flag_clr,
  input logic       rx_flag_clr,
  input logic       sclk,
  input logic       sd_oe
);
  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_flag && !tx_flag_clr) |=> tx_flag); // R8
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !rx_flag_clr) |=> rx_flag); // R8
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && rx_flag && !tx_we && ctrl_we && rx_en_wr) |=> !busy); // R7
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    (!busy && mode != 2'b00 && !ctrl_we) |=> !busy); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_flag) |-> (sclk && !sd_oe)); // R4
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && !sd_oe)); // R4
endmodule

bind ssp_shift_port ssp_checker u_chk (
  .clk(clk), .rst(rst), .busy(eng_busy), .mode(ctrl_rdata[3:2]),
  .ctrl_we(ctrl_we), .rx_en_wr(ctrl_wdata[0]), .tx_we(tx_we),
  .tx_flag(tx_flag), .rx_flag(rx_flag), .tx_flag_clr(tx_flag_clr),
  .rx_flag_clr(rx_flag_clr), .sclk(sclk), .sd_oe(sd_oe)
);

// File: tb/ssp_shift_port_tb.sv
module ssp_shift_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic [3:0] ctrl_rdata;
  logic       tx_we = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic       tx_flag, rx_flag;
  logic       tx_flag_clr = 1'b0, rx_flag_clr = 1'b0;
  logic       sd_in = 1'b0;
  logic       sd_out, sd_oe, sclk;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ssp_shift_port u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tx_we(tx_we), .tx_data(tx_data),
    .rx_data(rx_data), .tx_flag(tx_flag), .rx_flag(rx_flag),
    .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    step(); ctrl_we = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); tx_flag_clr = 1'b1; rx_flag_clr = 1'b1;
    step(); tx_flag_clr = 1'b0; rx_flag_clr = 1'b0;
  endtask

  // R2/R3/R4/R9: full transmit, every cycle checked; optional mid-frame disturbance
  task automatic t_tx(input logic [7:0] d, input bit fast, input bit disturb);
    int p = fast ? 4 : 12;
    int bad = 0;
    write_ctrl({2'b00, fast, 1'b0});
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    step(); tx_we = 1'b0;
    for (int j = 0; j < 8 * p; j++) begin
      if (j > 0) step();
      if (disturb && j == 20) begin
        tx_we = 1'b1; tx_data = ~d; ctrl_we = 1'b1; ctrl_wdata = {2'b00, ~fast, 1'b0};
      end else if (disturb && j == 21) begin
        tx_we = 1'b0; ctrl_we = 1'b0;
      end
      if (sd_oe !== 1'b1 || sd_out !== d[j / p] || sclk !== ((j % p) >= p / 2)) bad++;
    end
    check(disturb ? "R9 stream kept" : (fast ? "R3 fast stream" : "R2 slow stream"), bad, 0);
    step();
    check("R4 tx_flag at end", tx_flag, 1);
    check("R4 idle after tx", {sclk, sd_oe}, 2'b10);
    if (disturb) check("R9 ctrl stored", ctrl_rdata, {2'b00, ~fast, 1'b0});
  endtask

  // R5/R6: full receive
  task automatic t_rx(input logic [7:0] d, input bit fast);
    int p = fast ? 4 : 12;
    int bad = 0;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = {2'b00, fast, 1'b1};
    step(); ctrl_we = 1'b0;
    for (int j = 0; j < 8 * p; j++) begin
      if (j > 0) step();
      if (j % p == 0) sd_in = d[j / p];
      else if (j % p > p / 2) sd_in = ~d[j / p];
      if (sd_oe !== 1'b0 || sclk !== ((j % p) >= p / 2)) bad++;
    end
    check("R5 rx line/clock", bad, 0);
    step();
    check("R6 rx_data", rx_data, d);
    check("R6 rx_flag", rx_flag, 1);
  endtask

  // R7: reception blocked while rx_flag held
  task automatic t_rx_blocked();
    int bad = 0;
    logic [7:0] keep = rx_data;
    write_ctrl(4'b0001);
    for (int j = 0; j < 16; j++) begin
      sd_in = j[0];
      step();
      if (sclk !== 1'b1) bad++;
    end
    check("R7 no rx while flag", bad, 0);
    check("R7 rx_data kept", rx_data, keep);
    check("R8 rx_flag held", rx_flag, 1);
  endtask

  // R10: nonzero mode blocks both directions
  task automatic t_mode_gate();
    int bad = 0;
    write_ctrl(4'b0100);
    @(negedge clk); tx_we = 1'b1; tx_data = 8'hFF;
    step(); tx_we = 1'b0;
    write_ctrl(4'b1001);
    for (int j = 0; j < 20; j++) begin
      step();
      if (sclk !== 1'b1 || sd_oe !== 1'b0) bad++;
    end
    check("R10 no transfer", bad, 0);
    check("R10 no tx flag", tx_flag, 0);
    write_ctrl(4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 ctrl reset", ctrl_rdata, 0);
    check("R1 flags reset", {tx_flag, rx_flag}, 0);
    check("R1 line idle", {sclk, sd_oe}, 2'b10);

    t_tx(8'hA5, 1'b0, 1'b0);
    @(negedge clk); tx_flag_clr = 1'b1; step(); tx_flag_clr = 1'b0;
    check("R8 tx_flag cleared", tx_flag, 0);
    t_tx(8'h3C, 1'b1, 1'b0);
    clear_flags();
    t_tx(8'h96, 1'b0, 1'b1);
    clear_flags();
    t_rx(8'hC9, 1'b0);
    t_rx_blocked();
    clear_flags();
    check("R8 rx_flag cleared", rx_flag, 0);
    t_rx(8'h5E, 1'b1);
    clear_flags();
    t_mode_gate();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule